// File: doc/BRIEF.md
# Interrupt Request Priority Core

This block is the request and priority heart of an eight-level interrupt controller. It samples eight asynchronous request lines, records the pending levels, filters them through a mask and through the set of levels already being served, and raises a single interrupt line toward the processor whenever an eligible level outranks everything in service. Level 0 has the highest priority, level 7 the lowest.

An external acknowledge sequencer drives two strobes. `ack_set` commits the winning level: its in-service bit is set, its pending bit is dropped, and the chosen level is reported. `ack_end` marks the close of the final acknowledge pulse; in automatic end-of-interrupt mode this retires the level that was just acknowledged. Software end-of-interrupt commands arrive as a non-specific strobe, which retires the most urgent in-service level, or as a specific strobe with a level number. A neighbouring register file drives the mask write port and the trigger and end-of-interrupt mode selects, and it reads the three state vectors.

Top module: `irq_prio_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `irr_o`, `isr_o` and `imr_o` all zero, `int_out` low, `ack_level` equal to 7 and `ack_spurious` low.
- R2: Each request line passes through a two-flop synchronizer. A line raised just after a rising edge is first visible in `irr_o` after the third following rising edge, and not before.
- R3: With `cfg_level` low (edge triggering), a pending bit is set by a low-to-high change of the synchronized line, stays set while the line stays high, and clears when the synchronized line is low. A line held high after its acknowledge does not request again until it falls and rises.
- R4: With `cfg_level` high (level triggering), each pending bit follows the synchronized line; only in the cycle after an acknowledge is the acknowledged bit cleared, and it is set again one cycle later if the line is still high.
- R5: A mask write loads `imr_o` from `mask_din` (bit n = 1 masks level n). A masked level stays visible in `irr_o` but never raises `int_out` or wins an acknowledge, and it does not block lower-priority levels.
- R6: `int_out` is high exactly when some unmasked pending level has a smaller index than every set in-service bit (or no in-service bit is set).
- R7: On `ack_set` with an eligible level, the winner is the smallest-index unmasked pending level above the in-service level. On the next cycle its `isr_o` bit is set, its `irr_o` bit is clear, `ack_level` holds its index and `ack_spurious` is low.
- R8: On `ack_set` with no eligible level, the next cycle shows `ack_level` = 7 and `ack_spurious` high, and no in-service bit is set by that strobe.
- R9: With `cfg_auto_eoi` high, `ack_end` clears the in-service bit of `ack_level` unless `ack_spurious` is high. With `cfg_auto_eoi` low, `ack_end` has no effect.
- R10: `eoi_ns` clears the smallest-index set bit of `isr_o` and no other.
- R11: `eoi_sp` clears bit `eoi_lvl` of `isr_o`. When a clear and an acknowledge set target the same in-service bit in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Asynchronous request lines, bit n is level n |
| cfg_level | input | 1 | 1 = level triggering, 0 = edge triggering |
| cfg_auto_eoi | input | 1 | 1 = retire the level at `ack_end` |
| mask_we | input | 1 | Mask write strobe |
| mask_din | input | 8 | Mask value, 1 masks the level |
| ack_set | input | 1 | Acknowledge commit strobe |
| ack_end | input | 1 | End of the final acknowledge pulse |
| eoi_ns | input | 1 | Non-specific end-of-interrupt |
| eoi_sp | input | 1 | Specific end-of-interrupt |
| eoi_lvl | input | 3 | Level for the specific end-of-interrupt |
| int_out | output | 1 | Interrupt request to the processor |
| ack_level | output | 3 | Level chosen by the last acknowledge (7 when spurious) |
| ack_spurious | output | 1 | Last acknowledge found no eligible level |
| irr_o | output | 8 | Pending request vector |
| isr_o | output | 8 | In-service vector |
| imr_o | output | 8 | Mask vector |

## Verification
The bound checker watches, on every cycle, the reset values, that a spurious report always names level 7, that a committed acknowledge leaves its level in service and not spurious, that no interrupt is raised with no unmasked request, that an empty in-service set with an unmasked request always raises the interrupt, that a lone non-specific end-of-interrupt retires exactly one level, and that `ack_end` without automatic mode leaves the in-service set alone. The synchronizer latency, the difference between edge and level re-requesting after an acknowledge, a masked higher level not starving a lower one, and the choice of which bit each end-of-interrupt form retires are shown only by the bench's directed scenarios and its cycle model under random stimulus.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;

    localparam int IRQ_LEVELS = 8;
    localparam int IRQ_IDX_W  = $clog2(IRQ_LEVELS);

    typedef logic [IRQ_LEVELS-1:0] irq_vec_t;
    typedef logic [IRQ_IDX_W-1:0]  irq_idx_t;

    typedef struct packed {
        logic     hit;
        irq_idx_t idx;
    } irq_pick_t;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    localparam irq_idx_t SPURIOUS_IDX = irq_idx_t'(IRQ_LEVELS - 1);

    // Smallest set index wins (index 0 is the most urgent level).
    function automatic irq_pick_t pick_highest(irq_vec_t v);
        irq_pick_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int i = IRQ_LEVELS - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = irq_idx_t'(i);
            end
        end
        return r;
    endfunction

    // Levels strictly more urgent than the picked one; all levels when none picked.
    function automatic irq_vec_t outrank_mask(irq_pick_t p);
        irq_vec_t m;
        for (int i = 0; i < IRQ_LEVELS; i++) begin
            m[i] = !p.hit || (i < int'(p.idx));
        end
        return m;
    endfunction

    function automatic irq_vec_t one_hot(irq_idx_t idx);
        irq_vec_t m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge
    import irq_core_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t raw_in,
    output irq_vec_t lvl_s,
    output irq_vec_t rise_s
);

    localparam int LAST = STAGES - 1;

    irq_vec_t chain [STAGES];
    irq_vec_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= raw_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= '0;
            else     chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= chain[LAST];
    end

    assign lvl_s  = chain[LAST];
    assign rise_s = chain[LAST] & ~prev_q;

endmodule

// File: rtl/irq_request_reg.sv
module irq_request_reg
    import irq_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode,
    input  irq_vec_t   lvl_s,
    input  irq_vec_t   rise_s,
    input  irq_pick_t  ack_clr,
    output irq_vec_t   irr_q
);

    irq_vec_t base_d;
    irq_vec_t irr_d;

    always_comb begin
        unique case (mode)
            TRIG_LEVEL: base_d = lvl_s;
            default:    base_d = (irr_q | rise_s) & lvl_s;
        endcase
        irr_d = base_d;
        if (ack_clr.hit) irr_d = base_d & ~one_hot(ack_clr.idx);
    end

    always_ff @(posedge clk) begin
        if (rst) irr_q <= '0;
        else     irr_q <= irr_d;
    end

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_core_pkg::*;
(
    input  irq_vec_t  irr,
    input  irq_vec_t  imr,
    input  irq_vec_t  isr,
    output irq_pick_t isr_top,
    output irq_pick_t winner
);

    irq_vec_t req_v;
    irq_vec_t elig_v;

    always_comb begin
        req_v   = irr & ~imr;
        isr_top = pick_highest(isr);
        elig_v  = req_v & outrank_mask(isr_top);
        winner  = pick_highest(elig_v);
    end

endmodule

// File: rtl/irq_service_reg.sv
module irq_service_reg
    import irq_core_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      auto_eoi,
    input  logic      ack_set,
    input  logic      ack_end,
    input  logic      eoi_ns,
    input  logic      eoi_sp,
    input  irq_idx_t  eoi_lvl,
    input  irq_pick_t winner,
    input  irq_pick_t isr_top,
    output irq_vec_t  isr_q,
    output irq_idx_t  lvl_q,
    output logic      spur_q
);

    irq_vec_t set_v;
    irq_vec_t clr_v;
    irq_vec_t isr_d;

    always_comb begin
        set_v = '0;
        if (ack_set && winner.hit) set_v = one_hot(winner.idx);

        clr_v = '0;
        if (eoi_ns && isr_top.hit)            clr_v = clr_v | one_hot(isr_top.idx);
        if (eoi_sp)                           clr_v = clr_v | one_hot(eoi_lvl);
        if (ack_end && auto_eoi && !spur_q)   clr_v = clr_v | one_hot(lvl_q);

        isr_d = (isr_q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q  <= '0;
            lvl_q  <= SPURIOUS_IDX;
            spur_q <= 1'b0;
        end else begin
            isr_q <= isr_d;
            if (ack_set) begin
                lvl_q  <= winner.hit ? winner.idx : SPURIOUS_IDX;
                spur_q <= !winner.hit;
            end
        end
    end

endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_core_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IRQ_LEVELS-1:0] irq_in,
    input  logic                  cfg_level,
    input  logic                  cfg_auto_eoi,
    input  logic                  mask_we,
    input  logic [IRQ_LEVELS-1:0] mask_din,
    input  logic                  ack_set,
    input  logic                  ack_end,
    input  logic                  eoi_ns,
    input  logic                  eoi_sp,
    input  logic [IRQ_IDX_W-1:0]  eoi_lvl,
    output logic                  int_out,
    output logic [IRQ_IDX_W-1:0]  ack_level,
    output logic                  ack_spurious,
    output logic [IRQ_LEVELS-1:0] irr_o,
    output logic [IRQ_LEVELS-1:0] isr_o,
    output logic [IRQ_LEVELS-1:0] imr_o
);

    irq_vec_t   lvl_s;
    irq_vec_t   rise_s;
    irq_vec_t   irr_q;
    irq_vec_t   isr_q;
    irq_vec_t   imr_q;
    irq_pick_t  isr_top;
    irq_pick_t  winner;
    irq_pick_t  ack_clr;
    irq_idx_t   lvl_q;
    logic       spur_q;
    trig_mode_e mode;

    assign mode = trig_mode_e'(cfg_level);

    irq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (irq_in),
        .lvl_s  (lvl_s),
        .rise_s (rise_s)
    );

    always_comb begin
        ack_clr.hit = ack_set && winner.hit;
        ack_clr.idx = winner.idx;
    end

    irq_request_reg u_req (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .lvl_s   (lvl_s),
        .rise_s  (rise_s),
        .ack_clr (ack_clr),
        .irr_q   (irr_q)
    );

    always_ff @(posedge clk) begin
        if (rst)          imr_q <= '0;
        else if (mask_we) imr_q <= mask_din;
    end

    irq_resolver u_res (
        .irr     (irr_q),
        .imr     (imr_q),
        .isr     (isr_q),
        .isr_top (isr_top),
        .winner  (winner)
    );

    irq_service_reg u_svc (
        .clk      (clk),
        .rst      (rst),
        .auto_eoi (cfg_auto_eoi),
        .ack_set  (ack_set),
        .ack_end  (ack_end),
        .eoi_ns   (eoi_ns),
        .eoi_sp   (eoi_sp),
        .eoi_lvl  (eoi_lvl),
        .winner   (winner),
        .isr_top  (isr_top),
        .isr_q    (isr_q),
        .lvl_q    (lvl_q),
        .spur_q   (spur_q)
    );

    assign int_out      = winner.hit;
    assign ack_level    = lvl_q;
    assign ack_spurious = spur_q;
    assign irr_o        = irr_q;
    assign isr_o        = isr_q;
    assign imr_o        = imr_q;

endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk
    import irq_core_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  cfg_auto_eoi,
    input logic                  ack_set,
    input logic                  ack_end,
    input logic                  eoi_ns,
    input logic                  eoi_sp,
    input logic                  int_out,
    input logic [IRQ_IDX_W-1:0]  ack_level,
    input logic                  ack_spurious,
    input logic [IRQ_LEVELS-1:0] irr_o,
    input logic [IRQ_LEVELS-1:0] isr_o,
    input logic [IRQ_LEVELS-1:0] imr_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (irr_o == '0 && isr_o == '0 && imr_o == '0 && !ack_spurious
                 && ack_level == SPURIOUS_IDX)); // R1

    AST_SPURIOUS_IS_LOWEST: assert property (@(posedge clk) disable iff (rst)
        ack_spurious |-> ack_level == SPURIOUS_IDX); // R8

    AST_ACK_COMMITS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (ack_set && int_out) |=> (!ack_spurious && isr_o[ack_level])); // R7

    AST_NO_REQ_NO_INT: assert property (@(posedge clk) disable iff (rst)
        ((irr_o & ~imr_o) == '0) |-> !int_out); // R6

    AST_IDLE_REQ_RAISES_INT: assert property (@(posedge clk) disable iff (rst)
        (isr_o == '0 && (irr_o & ~imr_o) != '0) |-> int_out); // R6

    AST_NS_EOI_ONE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (eoi_ns && !eoi_sp && !ack_set && !ack_end && isr_o != '0)
        |=> $countones(isr_o) + 1 == $countones($past(isr_o))); // R10

    AST_END_WITHOUT_AUTO: assert property (@(posedge clk) disable iff (rst)
        (ack_end && !cfg_auto_eoi && !ack_set && !eoi_ns && !eoi_sp)
        |=> $stable(isr_o)); // R9

endmodule

bind irq_prio_core irq_prio_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_auto_eoi (cfg_auto_eoi),
    .ack_set      (ack_set),
    .ack_end      (ack_end),
    .eoi_ns       (eoi_ns),
    .eoi_sp       (eoi_sp),
    .int_out      (int_out),
    .ack_level    (ack_level),
    .ack_spurious (ack_spurious),
    .irr_o        (irr_o),
    .isr_o        (isr_o),
    .imr_o        (imr_o)
);

// File: tb/tb_irq_prio_core.sv
module tb_irq_prio_core;

    localparam int CLK_PERIOD = 10;
    localparam int NLVL       = 8;
    localparam int WATCHDOG   = 150000;

    logic            clk = 1'b0;
    logic            rst;
    logic [NLVL-1:0] irq_in;
    logic            cfg_level;
    logic            cfg_auto_eoi;
    logic            mask_we;
    logic [NLVL-1:0] mask_din;
    logic            ack_set;
    logic            ack_end;
    logic            eoi_ns;
    logic            eoi_sp;
    logic [2:0]      eoi_lvl;
    logic            int_out;
    logic [2:0]      ack_level;
    logic            ack_spurious;
    logic [NLVL-1:0] irr_o;
    logic [NLVL-1:0] isr_o;
    logic [NLVL-1:0] imr_o;

    irq_prio_core dut (
        .clk          (clk),
        .rst          (rst),
        .irq_in       (irq_in),
        .cfg_level    (cfg_level),
        .cfg_auto_eoi (cfg_auto_eoi),
        .mask_we      (mask_we),
        .mask_din     (mask_din),
        .ack_set      (ack_set),
        .ack_end      (ack_end),
        .eoi_ns       (eoi_ns),
        .eoi_sp       (eoi_sp),
        .eoi_lvl      (eoi_lvl),
        .int_out      (int_out),
        .ack_level    (ack_level),
        .ack_spurious (ack_spurious),
        .irr_o        (irr_o),
        .isr_o        (isr_o),
        .imr_o        (imr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    // reference state
    logic [NLVL-1:0] m_s1, m_s2, m_prev, m_irr, m_isr, m_imr;
    logic [2:0]      m_lvl;
    logic            m_spur;

    function automatic int lowest_set(logic [NLVL-1:0] v);
        for (int i = 0; i < NLVL; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int eligible_winner(logic [NLVL-1:0] irr, logic [NLVL-1:0] imr,
                                           logic [NLVL-1:0] isr);
        int top;
        int w;
        top = lowest_set(isr);
        w = lowest_set(irr & ~imr);
        if (w < 0) return -1;
        if (top >= 0 && w >= top) return -1;
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_s1 = '0; m_s2 = '0; m_prev = '0; m_irr = '0; m_isr = '0; m_imr = '0;
        m_lvl = 3'd7; m_spur = 1'b0;
    endtask

    task automatic compare_all();
        chk("R3/R4 irr_o", 32'(irr_o), 32'(m_irr));
        chk("R7/R9/R10/R11 isr_o", 32'(isr_o), 32'(m_isr));
        chk("R5 imr_o", 32'(imr_o), 32'(m_imr));
        chk("R7/R8 ack_level", 32'(ack_level), 32'(m_lvl));
        chk("R8 ack_spurious", 32'(ack_spurious), 32'(m_spur));
        chk("R6 int_out", 32'(int_out), 32'(eligible_winner(m_irr, m_imr, m_isr) >= 0));
    endtask

    // one clock: model computes next state from the inputs already driven
    task automatic step();
        logic [NLVL-1:0] rise, irr_n, isr_n, clr, setv;
        int w, top;
        rise = m_s2 & ~m_prev;
        w = eligible_winner(m_irr, m_imr, m_isr);
        top = lowest_set(m_isr);
        irr_n = cfg_level ? m_s2 : ((m_irr | rise) & m_s2);
        if (ack_set && w >= 0) irr_n[w] = 1'b0;
        clr = '0;
        setv = '0;
        if (eoi_ns && top >= 0) clr[top] = 1'b1;
        if (eoi_sp) clr[eoi_lvl] = 1'b1;
        if (ack_end && cfg_auto_eoi && !m_spur) clr[m_lvl] = 1'b1;
        if (ack_set && w >= 0) setv[w] = 1'b1;
        isr_n = (m_isr & ~clr) | setv;
        @(posedge clk);
        @(negedge clk);
        if (ack_set) begin
            m_lvl  = (w >= 0) ? 3'(w) : 3'd7;
            m_spur = (w < 0);
        end
        if (mask_we) m_imr = mask_din;
        m_irr  = irr_n;
        m_isr  = isr_n;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = irq_in;
        compare_all();
    endtask

    task automatic quiet();
        mask_we = 0; ack_set = 0; ack_end = 0; eoi_ns = 0; eoi_sp = 0;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1259);
        rst = 1; irq_in = '0; cfg_level = 0; cfg_auto_eoi = 0; mask_din = '0;
        eoi_lvl = '0;
        quiet();
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        // R1: reset values
        chk("R1 irr_o", 32'(irr_o), 0);
        chk("R1 isr_o", 32'(isr_o), 0);
        chk("R1 imr_o", 32'(imr_o), 0);
        chk("R1 int_out", 32'(int_out), 0);
        chk("R1 ack_level", 32'(ack_level), 7);
        chk("R1 ack_spurious", 32'(ack_spurious), 0);
        rst = 0;

        // R2: synchronizer latency
        irq_in = 8'h08;
        step(); chk("R2 not yet after 1 edge", 32'(irr_o), 0);
        step(); chk("R2 not yet after 2 edges", 32'(irr_o), 0);
        step(); chk("R2 visible after 3 edges", 32'(irr_o), 32'h08);
        chk("R6 int_out raised", 32'(int_out), 1);

        // R7: acknowledge commits level 3
        ack_set = 1; step(); quiet();
        chk("R7 isr set", 32'(isr_o), 32'h08);
        chk("R7 irr cleared", 32'(irr_o), 0);
        chk("R7 ack_level", 32'(ack_level), 3);

        // R3: held-high line does not request again in edge mode
        steps(4);
        chk("R3 no re-request", 32'(irr_o), 0);

        // R6/R10/R11: nested service and both end-of-interrupt forms
        irq_in = 8'h0A; steps(3);
        chk("R6 level 1 outranks in-service 3", 32'(int_out), 1);
        ack_set = 1; step(); quiet();
        chk("R7 nested isr", 32'(isr_o), 32'h0A);
        eoi_ns = 1; step(); quiet();
        chk("R10 non-specific retires level 1", 32'(isr_o), 32'h08);
        eoi_sp = 1; eoi_lvl = 3'd3; step(); quiet();
        chk("R11 specific retires level 3", 32'(isr_o), 0);

        // R8: spurious acknowledge
        irq_in = '0; steps(3);
        ack_set = 1; step(); quiet();
        chk("R8 spurious flag", 32'(ack_spurious), 1);
        chk("R8 spurious level", 32'(ack_level), 7);
        chk("R8 no isr set", 32'(isr_o), 0);

        // R5: masked higher level does not block a lower one
        mask_we = 1; mask_din = 8'h02; irq_in = 8'h22; step(); quiet();
        steps(2);
        chk("R5 masked bit still pending", 32'(irr_o), 32'h22);
        chk("R5 int from lower level", 32'(int_out), 1);
        ack_set = 1; step(); quiet();
        chk("R5 winner skips masked", 32'(ack_level), 5);
        eoi_ns = 1; step(); quiet();

        // R4: level mode re-requests while held high
        cfg_level = 1; mask_we = 1; mask_din = 8'h00; step(); quiet();
        ack_set = 1; step(); quiet();
        chk("R4 acked bit cleared", 32'(irr_o), 32'h20);
        step();
        chk("R4 bit back while high", 32'(irr_o), 32'h22);

        // R9: automatic retirement and ack_end without it
        eoi_ns = 1; step(); quiet();
        cfg_auto_eoi = 1; ack_set = 1; step(); quiet();
        chk("R9 in service before end", 32'(isr_o), 32'h02);
        ack_end = 1; step(); quiet();
        chk("R9 auto retire", 32'(isr_o), 0);
        cfg_auto_eoi = 0; step();
        ack_set = 1; step(); quiet();
        ack_end = 1; step(); quiet();
        chk("R9 end ignored without auto", 32'(isr_o), 32'h02);

        // random phases against the cycle model
        for (int ph = 0; ph < 12; ph++) begin
            cfg_level    = $urandom_range(0, 1);
            cfg_auto_eoi = $urandom_range(0, 1);
            for (int k = 0; k < 600; k++) begin
                if ($urandom_range(0, 7) == 0) irq_in = irq_in ^ (8'h1 << $urandom_range(0, 7));
                mask_we  = ($urandom_range(0, 31) == 0);
                mask_din = 8'($urandom) & 8'($urandom);
                ack_set  = ($urandom_range(0, 9) == 0);
                ack_end  = ($urandom_range(0, 9) == 0);
                eoi_ns   = ($urandom_range(0, 15) == 0);
                eoi_sp   = ($urandom_range(0, 19) == 0);
                eoi_lvl  = 3'($urandom_range(0, 7));
                step();
            end
            quiet();
        end

        finish_run();
    end

endmodule